// File: doc/BRIEF.md
# Variable-Latency Read Context Tracker

This block pairs every read issued to a pipelined memory with a short context record describing why the read was made and how its data must be handled. The issuing state machine hands over the record when it launches the read. When the memory later returns a data beat, the block takes the oldest record, joins it to the beat, and passes both to the processing state machine. The memory always answers in issue order and never fails, so a single queue of records is enough. The block does not count cycles and assumes no latency, so arbiters or pipeline stages can be added in front of the memory without changes here.

Each record holds a 5-bit port number, an opaque handling field and one flag bit. A port that goes down cannot cancel reads it already launched. Instead, a flush names the port, and every pending record of that port is tagged for discard. When a tagged record's beat returns, the block consumes it silently. Records belonging to other ports are left alone.

The queue depth is set from the worst-case read latency divided by the mean issue interval, plus a margin. When the queue is full, the block lowers the request-side ready signal. A beat therefore never arrives without a record to match it.

Top module: `rdctx_tracker`

## Requirements
- R1: During reset and in the first cycle after it, `out_valid` is 0 and `req_ready` is 1.
- R2: A beat with `rsp_valid`=1 while at least one record is pending pops the oldest record. When that record is not tagged, `out_valid` is 1 in the next cycle. In that cycle `out_data` equals the beat's `rsp_data`, and `out_port` and `out_info` equal the values pushed with the record. Beats come out in issue order.
- R3: `req_ready` is 0 exactly when DEPTH records are pending. A request offered while `req_ready` is 0 stores no record.
- R4: Any number of cycles, including zero, may pass between a push and its beat. A push and a pop may occur in the same cycle, and the pending count is then unchanged.
- R5: The flag bit `req_err` given with a request appears on `out_err` together with that request's data.
- R6: `flush_valid`=1 with `flush_port`=P tags every record of port P that was pending before that edge. A tagged record's beat still pops it, but produces `out_valid`=0.
- R7: A flush of port P does not change the delivery of records of any other port.
- R8: A request accepted in the same cycle as a flush of its own port is not tagged.
- R9: A beat that pops a record in the same cycle as a flush of that record's port is dropped.
- R10: A beat that arrives while no record is pending is ignored. It produces `out_valid`=0 and does not affect later records.
- R11: The block accepts one request per cycle and one beat per cycle, back to back, with no idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A read is being issued and its record is offered |
| req_ready | output | 1 | The queue has room for a record |
| req_port | input | 5 | Port owning the read |
| req_info | input | 8 | Handling instructions for the returned data |
| req_err | input | 1 | Per-request flag carried to completion |
| rsp_valid | input | 1 | A read data beat returns this cycle |
| rsp_data | input | DATA_W | Returned read data |
| flush_valid | input | 1 | Tag all pending records of `flush_port` |
| flush_port | input | 5 | Port to flush |
| out_valid | output | 1 | Data and record delivered to processing |
| out_data | output | DATA_W | Delivered read data |
| out_port | output | 5 | Port of the delivered record |
| out_info | output | 8 | Handling field of the delivered record |
| out_err | output | 1 | Flag of the delivered record |

## Verification
The hardest case to reach from the ports is a flush that lands in the same cycle as other traffic. A flush may coincide with a beat returning for the flushed port, with a new request for that port, or with records of other ports that sit between flushed ones in the queue. Directed sequences build each of these cases exactly. A long random phase then mixes pushes, beats and flushes over a small set of port numbers, so that tagged and untagged records interleave while the queue runs near full and near empty. A bench model of the queue predicts every delivered beat and every dropped beat.

// File: rtl/rdctx_pkg.sv
package rdctx_pkg;
  localparam int PORT_W = 5;
  localparam int INFO_W = 8;

  typedef struct packed {
    logic [PORT_W-1:0] port;
    logic [INFO_W-1:0] info;
    logic              err;
  } ctx_t;
endpackage

// File: rtl/rdctx_ptrs.sv
module rdctx_ptrs #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [AW-1:0] wr_idx_o,
  output logic [AW-1:0] rd_idx_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [AW:0] wr_q, wr_d, rd_q, rd_d, fill;

  always_comb begin
    wr_d = wr_q;
    rd_d = rd_q;
    if (push_i) wr_d = wr_q + 1'b1;
    if (pop_i)  rd_d = rd_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  assign fill     = wr_q - rd_q;
  assign full_o   = (fill == (AW+1)'(DEPTH));
  assign empty_o  = (fill == '0);
  assign wr_idx_o = wr_q[AW-1:0];
  assign rd_idx_o = rd_q[AW-1:0];
endmodule

// File: rtl/rdctx_store.sv
module rdctx_store
  import rdctx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_idx_i,
  input  ctx_t              wr_ctx_i,
  input  logic              flush_i,
  input  logic [PORT_W-1:0] flush_port_i,
  input  logic [AW-1:0]     rd_idx_i,
  output ctx_t              rd_ctx_o,
  output logic              rd_disc_o
);
  ctx_t             slot_rd [DEPTH];
  logic [DEPTH-1:0] disc_rd;

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    ctx_t slot_q;
    logic disc_q, disc_d, wr_hit, flush_hit;

    assign wr_hit    = wr_en_i && (wr_idx_i == AW'(s));
    assign flush_hit = flush_i && (slot_q.port == flush_port_i);

    // payload storage, loaded only on push
    always_ff @(posedge clk) begin
      if (wr_hit) slot_q <= wr_ctx_i;
    end

    // a fresh push wins over a flush of the same slot (new request is kept)
    always_comb begin
      disc_d = disc_q;
      if (wr_hit)         disc_d = 1'b0;
      else if (flush_hit) disc_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) disc_q <= 1'b0;
      else        disc_q <= disc_d;
    end

    assign slot_rd[s] = slot_q;
    assign disc_rd[s] = disc_q;
  end

  assign rd_ctx_o  = slot_rd[rd_idx_i];
  assign rd_disc_o = disc_rd[rd_idx_i];
endmodule

// File: rtl/rdctx_out.sv
module rdctx_out
  import rdctx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop_i,
  input  logic              drop_i,
  input  logic [DATA_W-1:0] data_i,
  input  ctx_t              ctx_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output ctx_t              ctx_o
);
  logic              valid_q, valid_d, load;
  logic [DATA_W-1:0] data_q, data_d;
  ctx_t              ctx_q, ctx_d;

  assign load = pop_i && !drop_i;

  always_comb begin
    valid_d = load;
    data_d  = data_q;
    ctx_d   = ctx_q;
    if (load) begin
      data_d = data_i;
      ctx_d  = ctx_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      ctx_q   <= '0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      ctx_q   <= ctx_d;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign ctx_o   = ctx_q;
endmodule

// File: rtl/rdctx_tracker.sv
module rdctx_tracker
  import rdctx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PORT_W-1:0] req_port,
  input  logic [INFO_W-1:0] req_info,
  input  logic              req_err,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              flush_valid,
  input  logic [PORT_W-1:0] flush_port,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [PORT_W-1:0] out_port,
  output logic [INFO_W-1:0] out_info,
  output logic              out_err
);
  localparam int AW = $clog2(DEPTH);

  logic              full, empty, push, pop, head_disc, drop;
  logic [AW-1:0]     wr_idx, rd_idx;
  logic [PORT_W-1:0] head_port;
  ctx_t              new_ctx, head_ctx, out_ctx;

  assign push      = req_valid && !full;
  assign pop       = rsp_valid && !empty;
  assign req_ready = !full;
  assign new_ctx   = '{port: req_port, info: req_info, err: req_err};
  assign head_port = head_ctx.port;
  // a flush in the popping cycle also drops the head
  assign drop      = head_disc || (flush_valid && (head_port == flush_port));

  rdctx_ptrs #(.DEPTH(DEPTH), .AW(AW)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
    .wr_idx_o(wr_idx), .rd_idx_o(rd_idx), .full_o(full), .empty_o(empty)
  );

  rdctx_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en_i(push), .wr_idx_i(wr_idx),
    .wr_ctx_i(new_ctx), .flush_i(flush_valid), .flush_port_i(flush_port),
    .rd_idx_i(rd_idx), .rd_ctx_o(head_ctx), .rd_disc_o(head_disc)
  );

  rdctx_out #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .pop_i(pop), .drop_i(drop),
    .data_i(rsp_data), .ctx_i(head_ctx),
    .valid_o(out_valid), .data_o(out_data), .ctx_o(out_ctx)
  );

  assign out_port = out_ctx.port;
  assign out_info = out_ctx.info;
  assign out_err  = out_ctx.err;
endmodule

// File: rtl/rdctx_tracker_chk.sv
module rdctx_tracker_chk #(
  parameter int DEPTH  = 16,
  parameter int PORT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              flush_valid,
  input logic [PORT_W-1:0] flush_port,
  input logic [PORT_W-1:0] head_port,
  input logic              out_valid
);
  localparam int CW = $clog2(DEPTH) + 1;
  logic [CW-1:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else pend <= pend + CW'(req_valid && req_ready) - CW'(rsp_valid && (pend != '0));
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && req_ready));

  p_ready_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == (pend != CW'(DEPTH)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= CW'(DEPTH));

  p_out_after_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_valid) |=> !out_valid);

  p_empty_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && pend == '0) |=> !out_valid);

  p_flush_same_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && pend != '0 && flush_valid && flush_port == head_port) |=> !out_valid);
endmodule

bind rdctx_tracker rdctx_tracker_chk #(.DEPTH(DEPTH), .PORT_W(rdctx_pkg::PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .flush_valid(flush_valid), .flush_port(flush_port),
  .head_port(head_port), .out_valid(out_valid)
);

// File: tb/rdctx_tracker_bench.sv
module rdctx_tracker_bench;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 32;

  typedef struct {
    logic [4:0] port;
    logic [7:0] info;
    logic       err;
    bit         disc;
  } mctx_t;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_err, rsp_valid, flush_valid;
  logic req_ready, out_valid, out_err;
  logic [4:0] req_port, flush_port, out_port;
  logic [7:0] req_info, out_info;
  logic [DATA_W-1:0] rsp_data, out_data;

  int checks = 0;
  int errors = 0;
  int n_out  = 0;
  mctx_t mq[$];

  always #4 clk = ~clk;

  rdctx_tracker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rdctx_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_port(req_port), .req_info(req_info), .req_err(req_err),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .flush_valid(flush_valid), .flush_port(flush_port),
    .out_valid(out_valid), .out_data(out_data), .out_port(out_port),
    .out_info(out_info), .out_err(out_err)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit model_ready();
    return mq.size() != DEPTH;
  endfunction

  // one cycle: drive at negedge, update model, check at next negedge
  task automatic step(input bit rv, input logic [4:0] rp, input logic [7:0] ri, input bit re,
                      input bit sv, input logic [DATA_W-1:0] sd,
                      input bit fv, input logic [4:0] fp);
    bit push_ok, exp_v;
    mctx_t h;
    string tag;
    logic [DATA_W-1:0] exp_d;
    chk(req_ready === model_ready(), "R3 ready", req_ready, model_ready());
    req_valid = rv; req_port = rp; req_info = ri; req_err = re;
    rsp_valid = sv; rsp_data = sd; flush_valid = fv; flush_port = fp;
    push_ok = rv && (mq.size() < DEPTH);
    exp_v = 0; tag = "R2"; exp_d = sd; h = '{default: '0};
    if (sv && mq.size() != 0) begin
      h = mq.pop_front();
      if (h.disc) begin tag = "R6"; exp_v = 0; end
      else if (fv && h.port == fp) begin tag = "R9"; exp_v = 0; end
      else exp_v = 1;
    end else if (sv) tag = "R10";
    if (fv) foreach (mq[k]) if (mq[k].port == fp) mq[k].disc = 1;
    if (push_ok) mq.push_back('{port: rp, info: ri, err: re, disc: 0});
    @(negedge clk);
    chk(out_valid === exp_v, {tag, " out_valid"}, out_valid, exp_v);
    if (out_valid) n_out++;
    if (exp_v && out_valid) begin
      chk(out_data === exp_d, "R2 data", out_data, exp_d);
      chk(out_port === h.port && out_info === h.info, "R2 context",
          {out_port, out_info}, {h.port, h.info});
      chk(out_err === h.err, "R5 flag", out_err, h.err);
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic push(input logic [4:0] p, input logic [7:0] i, input bit e);
    step(1, p, i, e, 0, 0, 0, 0);
  endtask

  task automatic beat();
    step(0, 0, 0, 0, 1, $urandom, 0, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base;
    void'($urandom(32'h5eed_0c7a));
    rst_n = 0; req_valid = 0; req_port = 0; req_info = 0; req_err = 0;
    rsp_valid = 0; rsp_data = 0; flush_valid = 0; flush_port = 0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(req_ready === 1'b1, "R1 req_ready in reset", req_ready, 1);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid === 1'b0 && req_ready === 1'b1, "R1 after release", {out_valid, req_ready}, 2'b01);

    // R3 / R11: fill back to back, offer one extra, drain back to back
    for (int i = 0; i < DEPTH; i++) push(5'(i), 8'(8'h40 + i), i[0]);
    chk(req_ready === 1'b0, "R3 full", req_ready, 0);
    push(5'd1, 8'hee, 1'b1);
    base = n_out;
    for (int i = 0; i < DEPTH; i++) beat();
    chk(n_out - base == DEPTH, "R11 back-to-back drain count", n_out - base, DEPTH);
    // R10: beat with nothing pending
    beat();
    chk(n_out - base == DEPTH, "R3 rejected request stored nothing", n_out - base, DEPTH);

    // R4: beat right after push, push and pop together, long wait
    push(5'd2, 8'h11, 0);
    step(1, 5'd2, 8'h12, 1, 1, 32'hAAAA_0001, 0, 0);
    step(1, 5'd2, 8'h13, 0, 1, 32'hAAAA_0002, 0, 0);
    repeat (40) idle();
    base = n_out;
    beat();
    chk(n_out - base == 1, "R4 beat after long latency", n_out - base, 1);

    // R6 / R7: interleaved ports, flush port 3
    push(3, 8'h31, 0); push(4, 8'h41, 1); push(3, 8'h32, 0); push(4, 8'h42, 0);
    step(0, 0, 0, 0, 0, 0, 1, 5'd3);
    base = n_out;
    repeat (4) beat();
    chk(n_out - base == 2, "R7 other port kept, R6 flushed dropped", n_out - base, 2);

    // R8: push during flush of same port survives
    push(6, 8'h61, 0);
    step(1, 5'd6, 8'h62, 1, 0, 0, 1, 5'd6);
    base = n_out;
    repeat (2) beat();
    chk(n_out - base == 1, "R8 same-cycle push kept", n_out - base, 1);

    // R9: flush in the popping cycle
    push(9, 8'h91, 0);
    base = n_out;
    step(0, 0, 0, 0, 1, 32'h9999_9999, 1, 5'd9);
    idle();
    chk(n_out - base == 0, "R9 same-cycle flush drops beat", n_out - base, 0);

    // random mix
    for (int c = 0; c < 4000; c++) begin
      bit rv, sv, fv;
      rv = ($urandom % 10) < 6;
      sv = (mq.size() != 0) && (($urandom % 10) < 5);
      fv = ($urandom % 32) == 0;
      step(rv, 5'($urandom % 8), 8'($urandom), 1'($urandom), sv, $urandom, fv, 5'($urandom % 8));
    end
    while (mq.size() != 0) beat();
    idle();
    finish_run();
  end
endmodule